// File: doc/BRIEF.md
# Bank-Interleaved SRAM Burst Controller

This block is a synchronous controller wrapped around a register model of a 2048-word memory that is split into 16 banks. Each bank stores two words on each of its 64 rows. The word address is split into three fields. The lowest bit picks the column inside a bank. The next four bits pick the bank. The top six bits pick the row. Because of this split, consecutive words go first across the two columns of a bank and then on to the next bank. A step to the next row happens only after bank 15 has been used.

A requester issues one access at a time through a valid/ready handshake. An access is a single-word read, a single-word write, or a four-word burst read. A burst reads four consecutive words at once from neighbouring banks and returns them together on a 128-bit read bus. Every access follows a fixed sequence. First comes a precharge cycle, then a word-line/sense cycle, then a result cycle. The phase enables are brought out as ports so that the sequencing can be watched.

All banks share one row decode. Banks that a burst reaches after wrapping past bank 15 take the next row instead. Read and write bank selection use separate decode paths.

Top module: `bank_burst_ctrl`

## Requirements
- R1: Address field positions: bit 0 is the column, bits 4:1 are the bank and bits 10:5 are the row. Each of the 2048 addresses holds its own word. A single write stores `req_wdata` at `req_addr`, and a later single read of that address returns it in lane 0 (`rd_data[31:0]`).
- R2: On a single read, lanes 1 to 3 (`rd_data[127:32]`) are zero in the result cycle.
- R3: On a burst read from address A, lane i (`rd_data[32*i+31:32*i]`) carries the word stored at address A+i, for i = 0 to 3.
- R4: A burst that runs past bank 15 continues at bank 0, column 0 of the next row.
- R5: A burst that runs past address 2047 (row 63, bank 15, column 1) continues at address 0.
- R6: A write with `req_burst` set stores exactly one word, at `req_addr`. Its neighbours keep their contents.
- R7: If a request is accepted at clock edge N, the following happens: `precharge` is high for the cycle after edge N; `wl_en` and `sense_en` are high for the cycle after edge N+1; `rd_valid` is high (reads only) for the cycle after edge N+2; `req_ready` is low for all three of those cycles and high again after edge N+3.
- R8: `wl_en` is never high in the same cycle as `precharge`.
- R9: A request presented while `req_ready` is low is ignored: it is not accepted and writes nothing.
- R10: Reset makes the controller idle: `req_ready` high, and `precharge`, `wl_en`, `sense_en` and `rd_valid` low. Memory contents survive reset.
- R11: A write never raises `rd_valid`, and `rd_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted at the edge where valid and ready are both high |
| req_addr | input | 11 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word burst read (ignored on writes) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | 128 | Four 32-bit lanes; lane i at bits 32*i+31:32*i |
| precharge | output | 1 | Precharge phase active |
| wl_en | output | 1 | Word-line enable |
| sense_en | output | 1 | Sense enable |

## Verification
The assertions assume that the request fields stay meaningful only at the edge where `req_valid` and `req_ready` are both high. They also assume that reset is asserted at start-up, so the synchronised reset defines the phase register before any property is evaluated. The bench changes inputs only on falling edges and holds each request until the edge that accepts it. It does hold `req_valid` high while the controller is busy, on purpose, to show that such requests are dropped. It releases reset on a falling edge and waits past the two synchroniser stages before it sends traffic.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned COL_W  = 1;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_WL   = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/bbc_seq.sv
module bbc_seq
  import bbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   precharge,
  output logic   wl_en,
  output logic   sense_en,
  output logic   ready
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_d = PH_PRE;
      PH_PRE:  ph_d = PH_WL;
      PH_WL:   ph_d = PH_DONE;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase     = ph_q;
  assign precharge = (ph_q == PH_PRE);
  assign wl_en     = (ph_q == PH_WL);
  assign sense_en  = (ph_q == PH_WL);
  assign ready     = (ph_q == PH_IDLE);

  // R8
  wl_pre_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wl_en && precharge));
  // R7
  start_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> (precharge && !ready));
  // R7
  pre_to_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |=> (wl_en && sense_en && !precharge));
  // R7
  wl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |=> (!wl_en && !sense_en && !ready));
endmodule

// File: rtl/bbc_decode.sv
module bbc_decode #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned COL_W  = 1,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned LANES  = 4,
  localparam int unsigned ROW_W = ADDR_W - COL_W - BANK_W,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic [ADDR_W-1:0] base,
  output logic [ROW_W-1:0]  bank_row  [NBANK],
  output logic [BANK_W-1:0] lane_bank [LANES],
  output logic [COL_W-1:0]  lane_col  [LANES],
  output logic [NBANK-1:0]  wr_sel
);
  logic [ROW_W-1:0]  base_row;
  logic [ROW_W-1:0]  next_row;
  logic [BANK_W-1:0] base_bank;

  assign base_row  = base[ADDR_W-1 -: ROW_W];
  assign next_row  = base_row + 1'b1;
  assign base_bank = base[COL_W +: BANK_W];

  // shared row decode; banks below the start bank were reached by wrapping
  for (genvar b = 0; b < NBANK; b++) begin : g_row
    assign bank_row[b] = (b < base_bank) ? next_row : base_row;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] la;
    assign la           = base + ADDR_W'(i);
    assign lane_bank[i] = la[COL_W +: BANK_W];
    assign lane_col[i]  = la[COL_W-1:0];
  end

  // write path bank decode, independent of the read lanes
  always_comb begin
    wr_sel = '0;
    for (int b = 0; b < NBANK; b++)
      if (base_bank == BANK_W'(b)) wr_sel[b] = 1'b1;
  end

  // R6
  wr_sel_onehot_chk: assert final ($onehot(wr_sel));
endmodule

// File: rtl/bbc_bank.sv
module bbc_bank #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned COL_W  = 1,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NCOL  = 1 << COL_W,
  localparam int unsigned DEPTH = (1 << ROW_W) * NCOL
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [ROW_W-1:0]       wrow,
  input  logic [COL_W-1:0]       wcol,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [ROW_W-1:0]       rrow,
  output logic [NCOL*DATA_W-1:0] rwords
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[{wrow, wcol}] <= wdata;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign rwords[c*DATA_W +: DATA_W] = cells[{rrow, COL_W'(c)}];
  end
endmodule

// File: rtl/bank_burst_ctrl.sv
module bank_burst_ctrl
  import bbc_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_COL_W  = COL_W,
  parameter int unsigned P_BANK_W = BANK_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_LANES  = LANES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [P_ADDR_W-1:0]           req_addr,
  input  logic                          req_we,
  input  logic                          req_burst,
  input  logic [P_DATA_W-1:0]           req_wdata,
  output logic                          rd_valid,
  output logic [P_LANES*P_DATA_W-1:0]   rd_data,
  output logic                          precharge,
  output logic                          wl_en,
  output logic                          sense_en
);
  localparam int unsigned ROW_W = P_ADDR_W - P_COL_W - P_BANK_W;
  localparam int unsigned NBANK = 1 << P_BANK_W;
  localparam int unsigned NCOL  = 1 << P_COL_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // phase sequencer
  phase_t phase;
  logic   accept;
  assign accept = req_valid && req_ready;

  bbc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (req_valid),
    .phase    (phase),
    .precharge(precharge),
    .wl_en    (wl_en),
    .sense_en (sense_en),
    .ready    (req_ready)
  );

  // captured request
  logic [P_ADDR_W-1:0] addr_q;
  logic                we_q, burst_q;
  logic [P_DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      burst_q <= req_burst && !req_we;
      wdata_q <= req_wdata;
    end
  end

  // decode
  logic [ROW_W-1:0]    bank_row  [NBANK];
  logic [P_BANK_W-1:0] lane_bank [P_LANES];
  logic [P_COL_W-1:0]  lane_col  [P_LANES];
  logic [NBANK-1:0]    wr_sel;

  bbc_decode #(
    .ADDR_W(P_ADDR_W), .COL_W(P_COL_W), .BANK_W(P_BANK_W), .LANES(P_LANES)
  ) u_dec (
    .base     (addr_q),
    .bank_row (bank_row),
    .lane_bank(lane_bank),
    .lane_col (lane_col),
    .wr_sel   (wr_sel)
  );

  // banks
  logic                     mem_wr;
  logic [NCOL*P_DATA_W-1:0] bank_rd [NBANK];
  assign mem_wr = (phase == PH_WL) && we_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bbc_bank #(.ROW_W(ROW_W), .COL_W(P_COL_W), .DATA_W(P_DATA_W)) u_bank (
      .clk   (clk),
      .we    (mem_wr && wr_sel[b]),
      .wrow  (addr_q[P_ADDR_W-1 -: ROW_W]),
      .wcol  (addr_q[P_COL_W-1:0]),
      .wdata (wdata_q),
      .rrow  (bank_row[b]),
      .rwords(bank_rd[b])
    );
  end

  // lane select
  logic [P_LANES*P_DATA_W-1:0] lanes_d;
  for (genvar i = 0; i < P_LANES; i++) begin : g_lsel
    logic [NCOL*P_DATA_W-1:0] pair;
    assign pair = bank_rd[lane_bank[i]];
    if (i == 0) begin : g_l0
      assign lanes_d[0 +: P_DATA_W] = pair[lane_col[i]*P_DATA_W +: P_DATA_W];
    end else begin : g_ln
      assign lanes_d[i*P_DATA_W +: P_DATA_W] =
        burst_q ? pair[lane_col[i]*P_DATA_W +: P_DATA_W] : '0;
    end
  end

  // result registers
  logic rd_cap;
  logic rd_valid_d;
  assign rd_cap     = (phase == PH_WL) && !we_q;
  assign rd_valid_d = rd_cap;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_valid <= 1'b0;
    else         rd_valid <= rd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rd_data <= '0;
    else if (rd_cap) rd_data <= lanes_d;
  end

  // R2
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && !burst_q) |-> (rd_data[P_LANES*P_DATA_W-1:P_DATA_W] == '0));
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |=> !rd_valid);
  // R11
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid) |-> !we_q);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!req_ready && !$rose(rst_ni)) |=> ($stable(addr_q) && $stable(we_q) && $stable(wdata_q)));
  // R6
  burst_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    we_q |-> !burst_q);
endmodule

// File: tb/bank_burst_ctrl_bench.sv
module bank_burst_ctrl_bench;
  localparam int NW = 2048;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [10:0]  req_addr = '0;
  logic         req_we = 1'b0;
  logic         req_burst = 1'b0;
  logic [31:0]  req_wdata = '0;
  logic         rd_valid;
  logic [127:0] rd_data;
  logic         precharge, wl_en, sense_en;

  bank_burst_ctrl u_bank_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_burst(req_burst),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .precharge(precharge), .wl_en(wl_en), .sense_en(sense_en)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] refm [NW];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int salt);
    logic [10:0] a11;
    a11 = 11'(a);
    return {5'(salt), a11, a11[9:0] ^ 10'h2A5, 6'h15};
  endfunction

  function automatic logic [127:0] exp_burst(input int a);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[32*i +: 32] = refm[(a + i) % NW];
    return v;
  endfunction

  // one access; returns phase observations and result
  task automatic access(input int a, input bit we, input bit bu, input logic [31:0] wd,
                        output bit o_pre, output bit o_wl, output bit o_val,
                        output logic [127:0] o_data, output bit o_idle);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 11'(a); req_we = we; req_burst = bu; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    o_pre = precharge && !wl_en && !sense_en && !req_ready && !rd_valid;
    @(negedge clk);
    o_wl = wl_en && sense_en && !precharge && !req_ready;
    @(negedge clk);
    o_val  = rd_valid && !req_ready && !wl_en && !precharge;
    o_data = rd_data;
    @(negedge clk);
    o_idle = req_ready && !rd_valid;
    if (we) refm[a] = wd;
  endtask

  task automatic t_reset();
    chk(req_ready, "R10 ready", 128'(req_ready), 128'd1);
    chk(!precharge && !wl_en && !sense_en, "R10 phases low",
        {precharge, wl_en, sense_en}, 0);
    chk(!rd_valid, "R10 rd_valid", 128'(rd_valid), 0);
  endtask

  task automatic t_fill();
    bit p, w, v, i; logic [127:0] d;
    bit any_valid = 0;
    for (int a = 0; a < NW; a++) begin
      access(a, 1'b1, 1'b0, pat(a, 3), p, w, v, d, i);
      if (v) any_valid = 1;
    end
    chk(!any_valid, "R11 write raised rd_valid", 128'(any_valid), 0);
  endtask

  task automatic t_single();
    bit p, w, v, i; logic [127:0] d;
    int addrs [6] = '{0, 1, 2, 33, 1055, 2047};
    foreach (addrs[k]) begin
      access(addrs[k], 1'b0, 1'b0, 0, p, w, v, d, i);
      chk(v && d[31:0] == refm[addrs[k]], "R1 single read lane0",
          d[31:0], refm[addrs[k]]);
      chk(d[127:32] == '0, "R2 upper lanes zero", d[127:32], 0);
    end
  endtask

  task automatic t_timing();
    bit p, w, v, i; logic [127:0] d;
    access(77, 1'b0, 1'b1, 0, p, w, v, d, i);
    chk(p, "R7 precharge cycle", 128'(p), 1);
    chk(w, "R7 R8 wordline/sense cycle", 128'(w), 1);
    chk(v, "R7 result cycle", 128'(v), 1);
    chk(i, "R7 R11 back to idle", 128'(i), 1);
  endtask

  task automatic t_burst();
    bit p, w, v, i; logic [127:0] d;
    int bases [4] = '{0, 5, 100, 1234};
    foreach (bases[k]) begin
      access(bases[k], 1'b0, 1'b1, 0, p, w, v, d, i);
      chk(v && d == exp_burst(bases[k]), "R3 burst lanes", d, exp_burst(bases[k]));
    end
  endtask

  task automatic t_bank_cross();
    bit p, w, v, i; logic [127:0] d;
    int bases [4] = '{29, 30, 31, 1023};
    foreach (bases[k]) begin
      access(bases[k], 1'b0, 1'b1, 0, p, w, v, d, i);
      chk(d == exp_burst(bases[k]), "R4 bank15 to next row", d, exp_burst(bases[k]));
    end
  endtask

  task automatic t_top_wrap();
    bit p, w, v, i; logic [127:0] d;
    int bases [3] = '{2045, 2046, 2047};
    foreach (bases[k]) begin
      access(bases[k], 1'b0, 1'b1, 0, p, w, v, d, i);
      chk(d == exp_burst(bases[k]), "R5 top wrap", d, exp_burst(bases[k]));
    end
  endtask

  task automatic t_burst_write();
    bit p, w, v, i; logic [127:0] d;
    access(200, 1'b1, 1'b1, 32'hC0DE_0200, p, w, v, d, i);
    chk(!v, "R6 R11 burst write no rd_valid", 128'(v), 0);
    access(199, 1'b0, 1'b1, 0, p, w, v, d, i);
    chk(d == exp_burst(199), "R6 one word written", d, exp_burst(199));
  endtask

  task automatic t_busy();
    bit p, w, v, i; logic [127:0] d;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 11'd500; req_we = 1'b0; req_burst = 1'b0;
    @(negedge clk);
    // controller now busy: present a write that must be dropped
    req_addr = 11'd600; req_we = 1'b1; req_wdata = 32'hDEAD_0600;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !precharge, "R9 no accept while busy",
        {req_ready, precharge}, 2'b10);
    req_valid = 1'b0; req_we = 1'b0;
    @(negedge clk);
    chk(!precharge, "R9 no late accept", 128'(precharge), 0);
    access(600, 1'b0, 1'b0, 0, p, w, v, d, i);
    chk(d[31:0] == refm[600], "R9 busy write ignored", d[31:0], refm[600]);
  endtask

  task automatic t_reset_keep();
    bit p, w, v, i; logic [127:0] d;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1500, 1'b0, 1'b1, 0, p, w, v, d, i);
    chk(d == exp_burst(1500), "R10 contents kept over reset", d, exp_burst(1500));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_single();
    t_timing();
    t_burst();
    t_bank_cross();
    t_top_wrap();
    t_burst_write();
    t_busy();
    t_reset_keep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule